// File: doc/BRIEF.md
# Dual-Threshold Audio Limiter Gain Controller

This block decides how much gain reduction a limiter applies to a group of audio channels. All arithmetic is in the dB domain. On each sample strobe it takes a signed level estimate. It compares that level with an attack threshold and a release threshold. When the level is above the attack threshold, the gain reduction grows by the attack step. When the level is below the release threshold and some reduction is already applied, the reduction shrinks by the release step. Between the two thresholds the reduction holds. The single reduction value it produces is applied to every channel of the group together.

Each threshold comes from its own 8-bit configuration byte. When bit 7 of that byte is set, the threshold is the fine 7-bit code in bits 6:0, in quarter-dB steps upward from -12 dB. When bit 7 is clear, the threshold comes from a separate 4-bit coarse code in 2 dB steps. The block captures the configuration bytes and coarse codes on every sample strobe, so a change takes effect one sample boundary later.

Levels and thresholds are signed values in 1/16 dB units. The gain reduction is unsigned, also in 1/16 dB units. Step sizes and the reduction ceiling are inputs.

Top module: `dual_thresh_limiter`

## Requirements
- R1: After reset `gainRed` is 0. The captured configuration bytes reset to 0x30 (fine mode off) and the captured coarse codes reset to 0. The first strobe after reset therefore uses an attack threshold of -12 dB (-192) and a release threshold of -30 dB (-480).
- R2: When bit 7 of the captured attack byte is 1, the attack threshold is -192 + 4*code in 1/16 dB, where code is bits 6:0.
- R3: When bit 7 of the captured attack byte is 0, the attack threshold is -192 + 32*k in 1/16 dB, where k is the captured 4-bit attack coarse code.
- R4: The release threshold is chosen independently of the attack threshold. If bit 7 of the release byte is 1 it is -192 + 4*code. Otherwise it is -480 + 32*k, where k is the release coarse code.
- R5: On a strobe where `levelIn` is strictly greater than the attack threshold, `gainRed` becomes min(`gainRed` + `atkStep`, `maxRed`).
- R6: On a strobe where `levelIn` is strictly below the release threshold and no attack occurs, a nonzero `gainRed` becomes max(`gainRed` - `relStep`, 0). A `gainRed` of 0 stays 0.
- R7: On a strobe whose level lies between the thresholds (inclusive), and on every cycle without a strobe, `gainRed` keeps its value.
- R8: Configuration and coarse codes present at strobe n decide the thresholds used at strobe n+1 and later, not at strobe n.
- R9: When the level is both above the attack threshold and below the release threshold, attack wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleStb | input | 1 | One-cycle sample boundary strobe |
| levelIn | input | LVL_W | Signed level estimate, 1/16 dB |
| atkCfg | input | 8 | Attack byte: bit 7 fine enable, bits 6:0 fine code |
| relCfg | input | 8 | Release byte: bit 7 fine enable, bits 6:0 fine code |
| atkLegacy | input | 4 | Coarse attack threshold code |
| relLegacy | input | 4 | Coarse release threshold code |
| atkStep | input | STEP_W | Attack increment per sample, 1/16 dB |
| relStep | input | STEP_W | Release decrement per sample, 1/16 dB |
| maxRed | input | GR_W | Gain reduction ceiling, 1/16 dB |
| gainRed | output | GR_W | Gain reduction shared by all mapped channels, 1/16 dB |

## Verification
A bad threshold decode or a stale capture register shows up at `gainRed` on the first strobe where the level sits exactly at a threshold or one unit past it. The bench therefore sweeps every fine code and every coarse code for both thresholds at those two levels. A wrong saturation or floor appears after only a few strobes at the ceiling or near zero. A capture register that is skipped, or updated on the same strobe that uses it, shows up within one sample of a configuration change, or on the very first strobe after reset.

// File: rtl/lim_pkg.sv
package lim_pkg;
  // Strobes from control to datapath, all valid only in a strobe cycle
  typedef struct packed {
    logic capture;
    logic doAttack;
    logic doRelease;
  } lim_strobe_t;

  localparam logic [7:0] CFG_RESET = 8'h30;
  localparam int FINE_BASE = -192;  // -12 dB in 1/16 dB
  localparam int FINE_STEP = 4;     // 0.25 dB
  localparam int COARSE_STEP = 32;  // 2 dB
  localparam int ATK_COARSE_BASE = -192;
  localparam int REL_COARSE_BASE = -480;
endpackage

// File: rtl/lim_thr_sel.sv
module lim_thr_sel #(
  parameter int LVL_W = 12,
  parameter int COARSE_BASE = -192
) (
  input  logic [7:0]              cfgQ,
  input  logic [3:0]              coarseQ,
  output logic signed [LVL_W-1:0] thr
);
  import lim_pkg::*;

  int fineVal;
  int coarseVal;

  always_comb begin
    fineVal   = FINE_BASE + FINE_STEP * int'(cfgQ[6:0]);
    coarseVal = COARSE_BASE + COARSE_STEP * int'(coarseQ);
    thr = cfgQ[7] ? LVL_W'(fineVal) : LVL_W'(coarseVal);
  end
endmodule

// File: rtl/lim_ctrl.sv
module lim_ctrl #(
  parameter int LVL_W = 12,
  parameter int GR_W = 10
) (
  input  logic                    sampleStb,
  input  logic signed [LVL_W-1:0] levelIn,
  input  logic signed [LVL_W-1:0] atkThr,
  input  logic signed [LVL_W-1:0] relThr,
  input  logic [GR_W-1:0]         gainRed,
  output lim_pkg::lim_strobe_t    strb
);
  logic aboveAtk;
  logic belowRel;

  always_comb begin
    aboveAtk = levelIn > atkThr;
    belowRel = levelIn < relThr;
    strb.capture   = sampleStb;
    strb.doAttack  = sampleStb && aboveAtk;
    strb.doRelease = sampleStb && !aboveAtk && belowRel && (gainRed != '0);
  end
endmodule

// File: rtl/lim_datapath.sv
module lim_datapath #(
  parameter int LVL_W = 12,
  parameter int GR_W = 10,
  parameter int STEP_W = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  lim_pkg::lim_strobe_t    strb,
  input  logic [7:0]              atkCfg,
  input  logic [7:0]              relCfg,
  input  logic [3:0]              atkLegacy,
  input  logic [3:0]              relLegacy,
  input  logic [STEP_W-1:0]       atkStep,
  input  logic [STEP_W-1:0]       relStep,
  input  logic [GR_W-1:0]         maxRed,
  output logic signed [LVL_W-1:0] atkThr,
  output logic signed [LVL_W-1:0] relThr,
  output logic [GR_W-1:0]         gainRed
);
  import lim_pkg::*;

  localparam int SUM_W = GR_W + 1;

  logic [7:0]       cfgQ    [2];
  logic [3:0]       coarseQ [2];
  logic [7:0]       cfgD    [2];
  logic [3:0]       coarseD [2];
  logic [SUM_W-1:0] atkSum;
  logic [GR_W-1:0]  atkNext;
  logic [GR_W-1:0]  relNext;

  assign cfgD[0]    = atkCfg;
  assign cfgD[1]    = relCfg;
  assign coarseD[0] = atkLegacy;
  assign coarseD[1] = relLegacy;

  // Index 0 is attack, index 1 is release
  for (genvar g = 0; g < 2; g++) begin : gCap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ[g]    <= CFG_RESET;
        coarseQ[g] <= '0;
      end else if (strb.capture) begin
        cfgQ[g]    <= cfgD[g];
        coarseQ[g] <= coarseD[g];
      end
    end
  end

  lim_thr_sel #(.LVL_W(LVL_W), .COARSE_BASE(ATK_COARSE_BASE)) u_atkSel (
    .cfgQ(cfgQ[0]), .coarseQ(coarseQ[0]), .thr(atkThr)
  );
  lim_thr_sel #(.LVL_W(LVL_W), .COARSE_BASE(REL_COARSE_BASE)) u_relSel (
    .cfgQ(cfgQ[1]), .coarseQ(coarseQ[1]), .thr(relThr)
  );

  always_comb begin
    atkSum  = {1'b0, gainRed} + SUM_W'(atkStep);
    atkNext = (atkSum > {1'b0, maxRed}) ? maxRed : atkSum[GR_W-1:0];
    relNext = (gainRed > GR_W'(relStep)) ? gainRed - GR_W'(relStep) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               gainRed <= '0;
    else if (strb.doAttack)  gainRed <= atkNext;
    else if (strb.doRelease) gainRed <= relNext;
  end
endmodule

// File: rtl/dual_thresh_limiter.sv
module dual_thresh_limiter #(
  parameter int LVL_W = 12,
  parameter int GR_W = 10,
  parameter int STEP_W = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleStb,
  input  logic signed [LVL_W-1:0] levelIn,
  input  logic [7:0]              atkCfg,
  input  logic [7:0]              relCfg,
  input  logic [3:0]              atkLegacy,
  input  logic [3:0]              relLegacy,
  input  logic [STEP_W-1:0]       atkStep,
  input  logic [STEP_W-1:0]       relStep,
  input  logic [GR_W-1:0]         maxRed,
  output logic [GR_W-1:0]         gainRed
);
  lim_pkg::lim_strobe_t    strb;
  logic signed [LVL_W-1:0] atkThr;
  logic signed [LVL_W-1:0] relThr;

  lim_ctrl #(.LVL_W(LVL_W), .GR_W(GR_W)) u_ctrl (
    .sampleStb(sampleStb), .levelIn(levelIn), .atkThr(atkThr),
    .relThr(relThr), .gainRed(gainRed), .strb(strb)
  );

  lim_datapath #(.LVL_W(LVL_W), .GR_W(GR_W), .STEP_W(STEP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .atkCfg(atkCfg), .relCfg(relCfg),
    .atkLegacy(atkLegacy), .relLegacy(relLegacy), .atkStep(atkStep),
    .relStep(relStep), .maxRed(maxRed), .atkThr(atkThr), .relThr(relThr),
    .gainRed(gainRed)
  );
endmodule

// File: rtl/lim_checker.sv
module lim_checker #(
  parameter int GR_W = 10
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sampleStb,
  input logic [GR_W-1:0]      gainRed,
  input logic [GR_W-1:0]      maxRed,
  input lim_pkg::lim_strobe_t strb
);
  // R5
  atk_ceiling_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doAttack |=> gainRed <= $past(maxRed));

  // R6
  rel_no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doRelease |=> gainRed <= $past(gainRed));

  // R6
  rel_needs_reduction_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doRelease |-> gainRed != '0);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb |=> $stable(gainRed));

  // R9
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doAttack, strb.doRelease}));

  // R7
  act_on_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doAttack || strb.doRelease) |-> sampleStb);
endmodule

bind dual_thresh_limiter lim_checker #(.GR_W(GR_W)) u_limChk (
  .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .gainRed(gainRed),
  .maxRed(maxRed), .strb(strb)
);

// File: tb/dual_thresh_limiter_bench.sv
module dual_thresh_limiter_bench;
  localparam int LVL_W = 12;
  localparam int GR_W = 10;
  localparam int STEP_W = 6;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    sampleStb = 1'b0;
  logic signed [LVL_W-1:0] levelIn = '0;
  logic [7:0]              atkCfg = 8'hB0;
  logic [7:0]              relCfg = 8'h30;
  logic [3:0]              atkLegacy = 4'd0;
  logic [3:0]              relLegacy = 4'd0;
  logic [STEP_W-1:0]       atkStep = 6'd5;
  logic [STEP_W-1:0]       relStep = 6'd3;
  logic [GR_W-1:0]         maxRed = 10'd600;
  logic [GR_W-1:0]         gainRed;

  int total = 0;
  int bad = 0;

  // Reference state
  logic [7:0] mAtkCfg = 8'h30;
  logic [7:0] mRelCfg = 8'h30;
  logic [3:0] mAtkLeg = 4'd0;
  logic [3:0] mRelLeg = 4'd0;
  int         mRed = 0;

  always #4 clk = ~clk;

  dual_thresh_limiter #(.LVL_W(LVL_W), .GR_W(GR_W), .STEP_W(STEP_W)) u_dual_thresh_limiter (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .levelIn(levelIn),
    .atkCfg(atkCfg), .relCfg(relCfg), .atkLegacy(atkLegacy),
    .relLegacy(relLegacy), .atkStep(atkStep), .relStep(relStep),
    .maxRed(maxRed), .gainRed(gainRed)
  );

  function automatic int thrOf(input logic [7:0] c, input logic [3:0] k, input int coarseBase);
    if (c[7]) return -192 + 4 * int'(c[6:0]);
    return coarseBase + 32 * int'(k);
  endfunction

  task automatic check(input string tag, input int exp);
    total++;
    if (int'(gainRed) != exp) begin
      bad++;
      $display("FAIL %s gainRed actual=%0d expected=%0d", tag, gainRed, exp);
    end
  endtask

  task automatic doStrobe(input int lvl, input string tag);
    int at;
    int rt;
    int s;
    @(negedge clk);
    at = thrOf(mAtkCfg, mAtkLeg, -192);
    rt = thrOf(mRelCfg, mRelLeg, -480);
    if (lvl > at) begin
      s = mRed + int'(atkStep);
      mRed = (s > int'(maxRed)) ? int'(maxRed) : s;
    end else if (lvl < rt && mRed > 0) begin
      mRed = (mRed > int'(relStep)) ? mRed - int'(relStep) : 0;
    end
    mAtkCfg = atkCfg; mRelCfg = relCfg; mAtkLeg = atkLegacy; mRelLeg = relLegacy;
    levelIn = LVL_W'(lvl);
    sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
    check(tag, mRed);
  endtask

  task automatic drain();
    while (mRed != 0) doStrobe(-2048, "R6");
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int th;
    repeat (3) @(negedge clk);
    check("R1 reset", 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 0);
    // R1: first strobe must use reset capture (-12 dB), not live byte 0xB0 (0 dB)
    doStrobe(-100, "R1");
    doStrobe(-100, "R8");
    drain();

    // R2: every fine attack code at and just above the threshold
    for (int c = 0; c < 128; c++) begin
      atkCfg = {1'b1, 7'(c)};
      doStrobe(-2048, "R2");
      drain();
      th = -192 + 4 * c;
      doStrobe(th, "R2");
      doStrobe(th + 1, "R2");
    end
    drain();

    // R3: every coarse attack code
    atkCfg = 8'h30;
    for (int k = 0; k < 16; k++) begin
      atkLegacy = 4'(k);
      doStrobe(-2048, "R3");
      drain();
      th = -192 + 32 * k;
      doStrobe(th, "R3");
      doStrobe(th + 1, "R3");
    end
    drain();

    // R4: release thresholds, fine then coarse, with attack threshold at top
    atkCfg = 8'hFF;
    for (int c = 0; c < 128; c++) begin
      relCfg = {1'b1, 7'(c)};
      doStrobe(2047, "R4");
      th = -192 + 4 * c;
      doStrobe(th, "R4");
      doStrobe(th - 1, "R4");
    end
    relCfg = 8'h30;
    for (int k = 0; k < 16; k++) begin
      relLegacy = 4'(k);
      doStrobe(2047, "R4");
      th = -480 + 32 * k;
      doStrobe(th, "R4");
      doStrobe(th - 1, "R4");
    end
    relLegacy = 4'd0;
    doStrobe(-2048, "R4");
    drain();

    // R5: ceiling
    atkCfg = 8'h30; atkLegacy = 4'd0; atkStep = 6'd10; maxRed = 10'd23;
    for (int i = 0; i < 6; i++) doStrobe(0, "R5");
    // R6: floor
    relStep = 6'd7;
    for (int i = 0; i < 6; i++) doStrobe(-2048, "R6");
    maxRed = 10'd600; atkStep = 6'd5; relStep = 6'd3;

    // R9: overlapping thresholds, attack wins
    atkCfg = 8'h80; relCfg = 8'hB0;
    doStrobe(-2048, "R9");
    for (int i = 0; i < 4; i++) doStrobe(-100, "R9");

    // R7: no strobe means no change
    relCfg = 8'h30;
    doStrobe(-300, "R7");
    levelIn = 12'sd2047;
    repeat (10) @(negedge clk);
    check("R7 idle", mRed);
    drain();

    // R8: new attack byte only acts one strobe later
    atkCfg = 8'hB0;
    doStrobe(-2048, "R8");
    atkCfg = 8'h80;
    doStrobe(-100, "R8");
    doStrobe(-100, "R8");
    finishRun();
  end
endmodule